// File: doc/BRIEF.md
# Pipelined Bus Cycle Sequencer

This block sits between a processor core and a 16-bit external bus with a 24-bit byte address. The core hands it one transfer at a time. Each transfer carries a word address, byte enables, a read or write flag, data/code and memory/IO qualifiers, a lock flag and write data. The sequencer turns each transfer into an external bus cycle. It drives the address, the active-low byte strobes, the cycle-definition pins and an active-low address strobe. It then waits for the active-low ready input to end the cycle.

A plain cycle uses an address state (T1) followed by one or more data states (T2). If the next-address input is low during a data state, the ready input is still high and a further transfer is already queued, the sequencer puts the queued transfer's address and definition on the bus early. This uses a T2 state with the next address already out (T2I). The pipelined cycle then runs as T1P and T2P. This choice is made anew for every cycle. When ready arrives and a transfer is queued, a new cycle follows at once with no idle state between them.

The core request side is a valid/ready handshake. The sequencer holds exactly one queued transfer and lowers `req_ready` while that slot is full. The core must hold its fields steady while `req_valid` is high and `req_ready` is low. The completion side has no back-pressure: `rsp_valid` is a single-clock pulse that the core must take when it appears.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held, and on leaving reset, the bus is idle. `bus_ads_n` is 1, every bit of `bus_be_n` is 1, `bus_lock_n` is 1, `bus_doe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: `req_ready` is 1 exactly when the single queue slot is empty. A transfer is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_ready` is 0 in the following clock.
- R3: A non-pipelined cycle starts with one T1 clock, in which `bus_ads_n` is 0 and the transfer's address and definition are on the bus. It continues in T2 with `bus_ads_n` at 1. If `rdy_n` is 0 at the end of the first T2, the cycle ends after two clocks.
- R4: While `rdy_n` is 1 in a data state, the data state repeats with no limit. The address and definition stay unchanged until the next strobe.
- R5: When a cycle ends in T2 or T2P and a transfer is queued, the next clock is T1 of the queued transfer, with `bus_ads_n` at 0. When nothing is queued, the bus goes idle.
- R6: A low `na_n` in T2 or T2P, with `rdy_n` high and a transfer queued, moves the bus to T2I. On the next clock the queued transfer's address and definition are on the bus and `bus_ads_n` is 0 for exactly one clock, while the current cycle keeps waiting for ready.
- R7: `na_n` has no effect in T1, T1P and T2I. It also has no effect when `rdy_n` is 0 on the same edge, and when no transfer is queued.
- R8: When ready arrives in T2I, the early-issued transfer enters T1P and then T2P. Ready is not sampled in T1P.
- R9: `bus_doe` is 1 in T2, T1P, T2P and T2I whenever the transfer in its data phase is a write, and 0 in idle and T1. `bus_dout` carries that transfer's write data.
- R10: On the clock edge where ready is sampled low, `bus_din` is captured. In the next clock `rsp_data` holds it and `rsp_valid` is 1 for exactly one clock.
- R11: The pins follow the transfer as follows. `bus_addr` equals `req_addr`, and `bus_be_n[i]` is the inverse of `req_be[i]`. `bus_wr` is 1 for a write. `bus_dc` equals `req_dc` and `bus_mio` equals `req_mio`. `bus_lock_n` is the inverse of `req_lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core offers a transfer |
| req_ready | output | 1 | Queue slot is empty |
| req_addr | input | 23 | Word address (byte address bits 23..1) |
| req_be | input | 2 | Byte enables, bit 1 is the upper byte |
| req_we | input | 1 | 1 = write, 0 = read |
| req_dc | input | 1 | Data (1) or code (0) |
| req_mio | input | 1 | Memory (1) or IO (0) |
| req_lock | input | 1 | Locked transfer |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_data | output | 16 | Data captured at completion |
| bus_addr | output | 23 | External word address |
| bus_be_n | output | 2 | Active-low byte strobes |
| bus_wr | output | 1 | Write (1) / read (0) |
| bus_dc | output | 1 | Data/code |
| bus_mio | output | 1 | Memory/IO |
| bus_lock_n | output | 1 | Active-low lock |
| bus_ads_n | output | 1 | Active-low address strobe |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Write data enable |
| bus_din | input | 16 | Read data from the bus |
| rdy_n | input | 1 | Active-low cycle end |
| na_n | input | 1 | Active-low request for early next address |

## Verification
The bench targets the handover points between cycles. A design that inserts an idle state after a completed cycle would show a late strobe. A design that issues the early address with no queued transfer, or in T2I, would raise a second strobe. A design that samples ready in T1P would end a pipelined cycle one clock early and pulse `rsp_valid` too soon. It also checks that the write enable stays on for the older write while the bus already shows the next read address, that ready and next-address low on the same edge give a plain T1, and that a reset in the middle of a write drops every strobe.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T1P  = 3'd3,
    ST_T2P  = 3'd4,
    ST_T2I  = 3'd5
  } bsq_state_e;

  // data states in which ready and next-address are both sampled
  function automatic logic waits_with_na(bsq_state_e s);
    return (s == ST_T2) || (s == ST_T2P);
  endfunction

  // states in which a transfer is in its data phase
  function automatic logic in_data_phase(bsq_state_e s);
    return (s == ST_T2) || (s == ST_T1P) || (s == ST_T2P) || (s == ST_T2I);
  endfunction

endpackage

// File: rtl/bsq_slot.sv
module bsq_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

endmodule

// File: rtl/bsq_fsm.sv
module bsq_fsm
  import bsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend_v,
  input  logic       rdy_n,
  input  logic       na_n,
  output bsq_state_e st_q,
  output logic       take_cur,
  output logic       take_nx,
  output logic       promote,
  output logic       done,
  output logic       ads_n
);

  bsq_state_e nxt;

  always_comb begin
    nxt      = st_q;
    take_cur = 1'b0;
    take_nx  = 1'b0;
    promote  = 1'b0;
    done     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (pend_v) begin
          take_cur = 1'b1;
          nxt      = ST_T1;
        end
      end
      ST_T1:  nxt = ST_T2;
      ST_T1P: nxt = ST_T2P;
      ST_T2, ST_T2P: begin
        if (!rdy_n) begin
          done = 1'b1;
          if (pend_v) begin
            take_cur = 1'b1;
            nxt      = ST_T1;
          end else begin
            nxt = ST_IDLE;
          end
        end else if (!na_n && pend_v) begin
          take_nx = 1'b1;
          nxt     = ST_T2I;
        end
      end
      ST_T2I: begin
        if (!rdy_n) begin
          done    = 1'b1;
          promote = 1'b1;
          nxt     = ST_T1P;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ads_n <= 1'b1;
    end else begin
      st_q  <= nxt;
      ads_n <= !((nxt == ST_T1) || ((nxt == ST_T2I) && (st_q != ST_T2I)));
    end
  end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bsq_pkg::*;
#(
  parameter  int ADDR_W = 24,
  parameter  int DATA_W = 16,
  localparam int AW     = ADDR_W - 1,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_we,
  input  logic              req_dc,
  input  logic              req_mio,
  input  logic              req_lock,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [AW-1:0]     bus_addr,
  output logic [BE_W-1:0]   bus_be_n,
  output logic              bus_wr,
  output logic              bus_dc,
  output logic              bus_mio,
  output logic              bus_lock_n,
  output logic              bus_ads_n,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              rdy_n,
  input  logic              na_n
);

  // slot layout, low to high: write data, lock, mio, dc, we, byte enables, address
  localparam int OFS_LK = DATA_W;
  localparam int OFS_MI = DATA_W + 1;
  localparam int OFS_DC = DATA_W + 2;
  localparam int OFS_WE = DATA_W + 3;
  localparam int OFS_BE = DATA_W + 4;
  localparam int OFS_AD = OFS_BE + BE_W;
  localparam int SLOT_W = OFS_AD + AW;

  logic [SLOT_W-1:0] req_pk, pend_q, nx_q, cur_q, cur_d, show;
  logic              pend_v, accept;
  logic              take_cur, take_nx, promote, done, ads_q, active;
  bsq_state_e        state_q;

  assign req_pk    = {req_addr, req_be, req_we, req_dc, req_mio, req_lock, req_wdata};
  assign req_ready = !pend_v;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pend_v <= 1'b0;
    else if (accept)               pend_v <= 1'b1;
    else if (take_cur || take_nx)  pend_v <= 1'b0;
  end

  bsq_slot #(.W(SLOT_W)) i_pend (
    .clk(clk), .rst_n(rst_n), .ld(accept), .d(req_pk), .q(pend_q)
  );

  bsq_slot #(.W(SLOT_W)) i_next (
    .clk(clk), .rst_n(rst_n), .ld(take_nx), .d(pend_q), .q(nx_q)
  );

  assign cur_d = take_cur ? pend_q : nx_q;

  bsq_slot #(.W(SLOT_W)) i_cur (
    .clk(clk), .rst_n(rst_n), .ld(take_cur || promote), .d(cur_d), .q(cur_q)
  );

  bsq_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .pend_v(pend_v), .rdy_n(rdy_n), .na_n(na_n),
    .st_q(state_q), .take_cur(take_cur), .take_nx(take_nx),
    .promote(promote), .done(done), .ads_n(ads_q)
  );

  // completion: capture on the ready edge, pulse one clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= done;
      if (done) rsp_data <= bus_din;
    end
  end

  // bus drive: in T2I the early-issued transfer owns the address pins
  assign active     = (state_q != ST_IDLE);
  assign show       = (state_q == ST_T2I) ? nx_q : cur_q;
  assign bus_addr   = show[OFS_AD +: AW];
  assign bus_be_n   = active ? ~show[OFS_BE +: BE_W] : '1;
  assign bus_wr     = active && show[OFS_WE];
  assign bus_dc     = active && show[OFS_DC];
  assign bus_mio    = active && show[OFS_MI];
  assign bus_lock_n = !(active && show[OFS_LK]);
  assign bus_ads_n  = ads_q;
  assign bus_dout   = cur_q[DATA_W-1:0];
  assign bus_doe    = cur_q[OFS_WE] && in_data_phase(state_q);

endmodule

// File: rtl/bsq_chk.sv
module bsq_chk
  import bsq_pkg::*;
#(
  parameter int AW = 23
) (
  input logic          clk,
  input logic          rst_n,
  input bsq_state_e    st,
  input logic          pend_v,
  input logic          rdy_n,
  input logic          na_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          bus_ads_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_doe,
  input logic          rsp_valid
);

  // R3
  ads_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ads_n |=> bus_ads_n);

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads_n |=> (!bus_ads_n || $stable(bus_addr)));

  // R2
  accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waits_with_na(st) && !rdy_n && pend_v) |=> (st == ST_T1 && !bus_ads_n));

  // R6
  early_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waits_with_na(st) && rdy_n && !na_n && pend_v) |=> (st == ST_T2I && !bus_ads_n));

  // R8
  t1p_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T1P) |=> (st == ST_T2P && !rsp_valid));

  // R9
  no_write_in_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T1) |-> !bus_doe);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

bind bus_cycle_seq bsq_chk #(.AW(ADDR_W - 1)) i_chk (
  .clk(clk), .rst_n(rst_n), .st(state_q), .pend_v(pend_v),
  .rdy_n(rdy_n), .na_n(na_n), .req_valid(req_valid), .req_ready(req_ready),
  .bus_ads_n(bus_ads_n), .bus_addr(bus_addr), .bus_doe(bus_doe),
  .rsp_valid(rsp_valid)
);

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_we, req_dc, req_mio, req_lock;
  logic [22:0] req_addr;
  logic [1:0]  req_be;
  logic [15:0] req_wdata, rsp_data, bus_dout, bus_din;
  logic        rsp_valid;
  logic [22:0] bus_addr;
  logic [1:0]  bus_be_n;
  logic        bus_wr, bus_dc, bus_mio, bus_lock_n, bus_ads_n, bus_doe;
  logic        rdy_n, na_n;

  int n_chk  = 0;
  int n_fail = 0;
  int k      = 0;
  logic finished = 1'b0;
  logic we_of_k [16];

  always #10 clk = ~clk;

  bus_cycle_seq i_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_be(req_be), .req_we(req_we), .req_dc(req_dc),
    .req_mio(req_mio), .req_lock(req_lock), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .bus_addr(bus_addr),
    .bus_be_n(bus_be_n), .bus_wr(bus_wr), .bus_dc(bus_dc), .bus_mio(bus_mio),
    .bus_lock_n(bus_lock_n), .bus_ads_n(bus_ads_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din), .rdy_n(rdy_n), .na_n(na_n)
  );

  // transfer number n carries fields computed from n
  function automatic logic [22:0] addr_of(int n); return 23'h1000 + 23'(n * 3); endfunction
  function automatic logic [1:0]  be_of(int n);   return 2'((n % 3) + 1);       endfunction
  function automatic logic        dc_of(int n);   return n[0];                  endfunction
  function automatic logic        mio_of(int n);  return !n[1];                 endfunction
  function automatic logic        lock_of(int n); return (n == 3);              endfunction
  function automatic logic [15:0] wd_of(int n);   return 16'h5A00 + 16'(n);     endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // drive one clock of inputs at a falling edge, then move to the next falling edge
  task automatic cyc(input logic rv, input logic we, input logic rdy, input logic na,
                     input logic [15:0] din);
    req_valid = rv;
    if (rv) begin
      check("R2 ready before offer", {31'd0, req_ready}, 32'd1);
      req_we = we; req_addr = addr_of(k); req_be = be_of(k); req_dc = dc_of(k);
      req_mio = mio_of(k); req_lock = lock_of(k); req_wdata = wd_of(k);
      we_of_k[k] = we;
      k++;
    end
    rdy_n = rdy; na_n = na; bus_din = din;
    @(negedge clk);
  endtask

  task automatic check_bus(input string rq, input int t);
    check({rq, " addr"}, {9'd0, bus_addr}, {9'd0, addr_of(t)});
    check({rq, " be_n"}, {30'd0, bus_be_n}, {30'd0, ~be_of(t)});
    check({rq, " wr"},   {31'd0, bus_wr}, {31'd0, we_of_k[t]});
    check({rq, " dc/mio/lock_n"}, {29'd0, bus_dc, bus_mio, bus_lock_n},
          {29'd0, dc_of(t), mio_of(t), !lock_of(t)});
  endtask

  task automatic check_reset_state(input string rq);
    check({rq, " ads_n"}, {31'd0, bus_ads_n}, 32'd1);
    check({rq, " be_n"}, {30'd0, bus_be_n}, 32'd3);
    check({rq, " lock_n"}, {31'd0, bus_lock_n}, 32'd1);
    check({rq, " doe"}, {31'd0, bus_doe}, 32'd0);
    check({rq, " rsp_valid"}, {31'd0, rsp_valid}, 32'd0);
    check({rq, " req_ready"}, {31'd0, req_ready}, 32'd1);
  endtask

  typedef struct packed {
    logic       rv, we, rdy, na;       // inputs for this clock
    logic       ads;                   // expected bus_ads_n after the edge
    logic [2:0] tag;                   // transfer on the address pins, 7 = idle
    logic       doe;                   // expected bus_doe
    logic [2:0] wtag;                  // transfer whose data is driven
    logic       rsp;                   // expected rsp_valid
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1,0,1,1, 1,7,0,0,0},   // 0: offer A (read)
    '{0,0,1,1, 0,0,0,0,0},   // 1: T1 of A
    '{1,1,1,1, 1,0,0,0,0},   // 2: T2 of A, offer B (write)
    '{0,0,0,1, 0,1,0,0,1},   // 3: A ends, B T1 at once
    '{0,0,1,1, 1,1,1,1,0},   // 4: T2 of B
    '{0,0,1,1, 1,1,1,1,0},   // 5: wait state
    '{0,0,0,1, 1,7,0,0,1},   // 6: B ends, nothing queued: idle
    '{1,0,1,1, 1,7,0,0,0},   // 7: offer C (read)
    '{0,0,1,1, 0,2,0,0,0},   // 8: T1 of C
    '{1,1,1,1, 1,2,0,0,0},   // 9: T2 of C, offer D (write, locked)
    '{0,0,1,0, 0,3,0,0,0},   // 10: next-address: D issued early
    '{1,0,1,0, 1,3,0,0,0},   // 11: T2I again, na ignored, offer E
    '{0,0,0,1, 1,3,1,3,1},   // 12: C ends, D in T1P
    '{0,0,1,0, 1,3,1,3,0},   // 13: T2P of D, na in T1P ignored
    '{0,0,1,0, 0,4,1,3,0},   // 14: E issued early, D data still out
    '{0,0,0,1, 1,4,0,0,1},   // 15: D ends, E in T1P
    '{0,0,0,1, 1,4,0,0,0},   // 16: ready ignored in T1P
    '{0,0,1,0, 1,4,0,0,0},   // 17: na with empty queue ignored
    '{0,0,0,1, 1,7,0,0,1},   // 18: E ends, idle
    '{0,0,1,1, 1,7,0,0,0}    // 19: idle
  };

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_be = '0;
    req_dc = 1'b0; req_mio = 1'b0; req_lock = 1'b0; req_wdata = '0;
    rdy_n = 1'b1; na_n = 1'b1; bus_din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1 in reset");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].rv, VEC[i].we, VEC[i].rdy, VEC[i].na, 16'hC000 + 16'(i));
      if (i == 0) check("R2 slot full", {31'd0, req_ready}, 32'd0);
      check($sformatf("R3 R6 R8 ads v%0d", i), {31'd0, bus_ads_n}, {31'd0, VEC[i].ads});
      if (VEC[i].tag == 3'd7) begin
        check($sformatf("R1 idle be_n v%0d", i), {30'd0, bus_be_n}, 32'd3);
        check($sformatf("R1 idle lock_n v%0d", i), {31'd0, bus_lock_n}, 32'd1);
      end else begin
        check_bus($sformatf("R4 R11 v%0d", i), int'(VEC[i].tag));
      end
      check($sformatf("R9 doe v%0d", i), {31'd0, bus_doe}, {31'd0, VEC[i].doe});
      if (VEC[i].doe)
        check($sformatf("R9 dout v%0d", i), {16'd0, bus_dout}, {16'd0, wd_of(int'(VEC[i].wtag))});
      check($sformatf("R8 R10 rsp_valid v%0d", i), {31'd0, rsp_valid}, {31'd0, VEC[i].rsp});
      if (VEC[i].rsp)
        check($sformatf("R10 rsp_data v%0d", i), {16'd0, rsp_data}, {16'd0, 16'hC000 + 16'(i)});
    end

    // R5 R7: ready and next-address low on the same edge give a plain T1
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 16'h0);          // offer F (5)
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 16'h0);          // T1 of F
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 16'h0);          // T2 of F, offer G (6, write)
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 16'hD00D);       // F ends with na low
    check("R5 R7 ads for G", {31'd0, bus_ads_n}, 32'd0);
    check_bus("R5 G on bus", 6);
    check("R7 no early write data", {31'd0, bus_doe}, 32'd0);
    check("R10 F data", {16'd0, rsp_data}, 32'h0000D00D);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 16'h0);          // T2 of G, na with empty queue
    check("R7 na ignored empty queue", {31'd0, bus_ads_n}, 32'd1);
    check("R9 G data", {16'd0, bus_dout}, {16'd0, wd_of(6)});
    check("R9 G doe", {31'd0, bus_doe}, 32'd1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 16'h0);          // wait state
    check("R4 wait keeps G", {9'd0, bus_addr}, {9'd0, addr_of(6)});
    check("R4 wait doe", {31'd0, bus_doe}, 32'd1);

    // R1: reset in the middle of a write drops every strobe
    rst_n = 1'b0;
    @(negedge clk);
    check_reset_state("R1 mid-cycle reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1 after release");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule